// File: doc/BRIEF.md
# DDR3 mode register command builder

This block turns a structured mode-register request into the 19-bit command word that a DDR3 memory controller places on the address and bank pins during a mode-register-set cycle. A request strobe arrives together with the number of the target register (0 to 3), a mirroring flag and the field values for every register. The block encodes the fields of the selected register into their pin positions and registers the result. The command word appears one clock later with a single-cycle valid pulse.

Several fields are not plain binary copies. Write recovery is rounded to the values the device supports. The CAS latency offset is split across two separate pin groups. The nominal termination and drive-strength codes are scattered over non-adjacent address pins. The write CAS latency is stored as an offset from five. For ranks whose address routing is mirrored on the module, the block swaps the affected address and bank pin pairs before the word is registered. Putting the command on the bus and sequencing initialization are left to the surrounding controller.

Top module: `mrs_cmd_builder`

## Requirements
- R1: The command word carries the address in bits 15:0 and the bank address in bits 18:16. Bit 18 is always 0, and bits 17:16 hold the selected register number `req_mr` unless mirroring applies.
- R2: For register 0, bits 11:9 hold the write-recovery code: tWR of 5 to 8 gives tWR-4, tWR of 9 to 14 gives (tWR+1)/2 (odd values round up), and any other value gives 0.
- R3: For register 0, with k = (CAS-4) mod 16, bits 6:4 hold k[2:0] and bit 2 holds k[3].
- R4: For register 0, bit 12 is fast precharge power-down, bit 8 is DLL reset, bit 7 is test mode, bit 3 is interleaved burst, and bits 1:0 are the burst-length code.
- R5: For register 1, termination code bits 2, 1 and 0 land on address bits 9, 6 and 2, and drive-strength bits 1 and 0 land on address bits 5 and 1.
- R6: For register 1, bit 12 is output disable, bit 11 is the termination-data-strobe enable, bit 7 is write leveling, bits 4:3 are additive latency and bit 0 is DLL disable.
- R7: For register 2, bits 10:9 hold the write termination code, bit 7 extended temperature, bit 6 auto self-refresh, and bits 5:3 hold (CWL-5) mod 8.
- R8: For register 3, bit 2 enables the read path from the multipurpose register, and every other address bit is 0.
- R9: Address bits not assigned to a field of the selected register are 0, and the fields of the registers that were not selected have no effect on the word.
- R10: When `req_mirror` is 1, address bit 3 is swapped with bit 4, bit 5 with bit 6, bit 7 with bit 8, and bank bit 0 with bank bit 1. No other bit moves.
- R11: The word and a one-cycle `cmd_valid` pulse appear on the clock edge after a sampled `req_strobe`, and back-to-back strobes give back-to-back words. Without a strobe, `cmd_valid` is 0 and the word holds its last value.
- R12: While `rst_n` is low at a clock edge, `cmd_valid` and `cmd_word` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_strobe | input | 1 | Request strobe; the request is sampled on this edge |
| req_mr | input | 2 | Target mode register number |
| req_mirror | input | 1 | Apply the rank address mirroring swap |
| mr0_fast_pd | input | 1 | Fast precharge power-down exit |
| mr0_twr | input | 5 | Write recovery in clocks |
| mr0_dll_reset | input | 1 | DLL reset request |
| mr0_test_mode | input | 1 | Test mode |
| mr0_cas | input | 5 | CAS latency in clocks |
| mr0_interleave | input | 1 | Interleaved burst order |
| mr0_burst_len | input | 2 | Burst length code |
| mr1_out_off | input | 1 | Output buffer disable |
| mr1_tdqs_en | input | 1 | Termination data strobe enable |
| mr1_rtt_nom | input | 3 | Nominal termination code |
| mr1_wr_level | input | 1 | Write leveling enable |
| mr1_drive | input | 2 | Output drive strength code |
| mr1_add_lat | input | 2 | Additive latency code |
| mr1_dll_off | input | 1 | DLL disable |
| mr2_rtt_wr | input | 2 | Dynamic write termination code |
| mr2_ext_temp | input | 1 | Extended temperature self-refresh range |
| mr2_auto_sr | input | 1 | Auto self-refresh |
| mr2_cwl | input | 4 | CAS write latency in clocks |
| mr3_mpr_en | input | 1 | Multipurpose register read path enable |
| cmd_valid | output | 1 | One-cycle valid pulse for the command word |
| cmd_word | output | 19 | Bank address (18:16) and address (15:0) |

## Verification
The block holds almost no state, so a wrong encoding shows up directly as a wrong bit in `cmd_word` on the edge right after the strobe. A broken output register shows up as a missing or stretched `cmd_valid` pulse, or as a word that drifts while no strobe is present, within one cycle. The sweeps cover every write-recovery and CAS value, every termination, drive and additive-latency code, and every write CAS latency. Each request is issued with random values on the fields of the registers that are not selected, and mirrored and unmirrored requests are mixed, so a misrouted or leaking bit is visible on the first affected request.

// File: rtl/mrs_pkg.sv
// Package: shared field widths and request structures for the mode register
// command builder. Assumes the standard four-register DDR3 layout.
package mrs_pkg;
    localparam int TWR_W = 5;   // write recovery input width (clocks)
    localparam int CAS_W = 5;   // CAS latency input width (clocks)
    localparam int CWL_W = 4;   // CAS write latency input width (clocks)

    typedef struct packed {
        logic             fast_pd;
        logic [TWR_W-1:0] twr;
        logic             dll_reset;
        logic             test_mode;
        logic [CAS_W-1:0] cas;
        logic             interleave;
        logic [1:0]       burst_len;
    } mr0_fields_t;

    typedef struct packed {
        logic       out_off;
        logic       tdqs_en;
        logic [2:0] rtt_nom;
        logic       wr_level;
        logic [1:0] drive;
        logic [1:0] add_lat;
        logic       dll_off;
    } mr1_fields_t;

    typedef struct packed {
        logic [1:0]       rtt_wr;
        logic             ext_temp;
        logic             auto_sr;
        logic [CWL_W-1:0] cwl;
    } mr2_fields_t;

    typedef enum logic [1:0] {
        MR_SEL0 = 2'd0,
        MR_SEL1 = 2'd1,
        MR_SEL2 = 2'd2,
        MR_SEL3 = 2'd3
    } mr_sel_e;
endpackage

// File: rtl/mrs_mr0_enc.sv
// Module: mrs_mr0_enc
// Encodes the register-0 fields into address pins. Converts write recovery to
// its rounded code and splits the CAS offset over bits 6:4 and bit 2.
// Assumes ADDR_W >= 13. Pure combinational.
module mrs_mr0_enc
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  mr0_fields_t       fields,
    output logic [ADDR_W-1:0] addr
);
    logic [2:0] twr_code;
    logic [3:0] cas_off;

    // Map write recovery clocks to the 3-bit code (R2).
    always_comb begin
        if (fields.twr >= TWR_W'(5) && fields.twr <= TWR_W'(8))
            twr_code = 3'(fields.twr - TWR_W'(4));
        else if (fields.twr >= TWR_W'(9) && fields.twr <= TWR_W'(14))
            twr_code = 3'((fields.twr + TWR_W'(1)) >> 1);
        else
            twr_code = 3'd0;
    end

    // CAS offset from four, kept modulo 16 (R3).
    always_comb cas_off = 4'(fields.cas - CAS_W'(4));

    // Place every register-0 field on its pin; other pins stay zero (R4, R9).
    always_comb begin
        addr       = '0;
        addr[12]   = fields.fast_pd;
        addr[11:9] = twr_code;
        addr[8]    = fields.dll_reset;
        addr[7]    = fields.test_mode;
        addr[6:4]  = cas_off[2:0];
        addr[3]    = fields.interleave;
        addr[2]    = cas_off[3];
        addr[1:0]  = fields.burst_len;
    end
endmodule

// File: rtl/mrs_mr1_enc.sv
// Module: mrs_mr1_enc
// Encodes the register-1 fields, scattering the termination and drive codes
// over non-adjacent pins. Assumes ADDR_W >= 13. Pure combinational.
module mrs_mr1_enc
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  mr1_fields_t       fields,
    output logic [ADDR_W-1:0] addr
);
    // Place the scattered and contiguous register-1 fields (R5, R6, R9).
    always_comb begin
        addr      = '0;
        addr[12]  = fields.out_off;
        addr[11]  = fields.tdqs_en;
        addr[9]   = fields.rtt_nom[2];
        addr[7]   = fields.wr_level;
        addr[6]   = fields.rtt_nom[1];
        addr[5]   = fields.drive[1];
        addr[4:3] = fields.add_lat;
        addr[2]   = fields.rtt_nom[0];
        addr[1]   = fields.drive[0];
        addr[0]   = fields.dll_off;
    end
endmodule

// File: rtl/mrs_mr23_enc.sv
// Module: mrs_mr23_enc
// Encodes registers 2 and 3. The write CAS latency is stored as an offset
// from five, modulo eight. Assumes ADDR_W >= 11. Pure combinational.
module mrs_mr23_enc
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  mr2_fields_t       fields2,
    input  logic              mpr_en,
    output logic [ADDR_W-1:0] addr2,
    output logic [ADDR_W-1:0] addr3
);
    logic [2:0] cwl_off;

    // Write CAS latency offset from five (R7).
    always_comb cwl_off = 3'(fields2.cwl - CWL_W'(5));

    // Register-2 pin placement (R7, R9).
    always_comb begin
        addr2       = '0;
        addr2[10:9] = fields2.rtt_wr;
        addr2[7]    = fields2.ext_temp;
        addr2[6]    = fields2.auto_sr;
        addr2[5:3]  = cwl_off;
    end

    // Register-3 pin placement: only the read-path enable (R8).
    always_comb begin
        addr3    = '0;
        addr3[2] = mpr_en;
    end
endmodule

// File: rtl/mrs_mirror.sv
// Module: mrs_mirror
// Optionally swaps NUM_PAIRS adjacent address pin pairs starting at
// FIRST_LSB (stride two) and the two low bank pins, for mirrored ranks.
// Assumes BANK_W >= 2 and the pairs fit inside ADDR_W. Pure combinational.
module mrs_mirror #(
    parameter int ADDR_W    = 16,
    parameter int BANK_W    = 3,
    parameter int FIRST_LSB = 3,
    parameter int NUM_PAIRS = 3
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BANK_W-1:0] bank_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BANK_W-1:0] bank_out
);
    localparam int LAST_BIT = FIRST_LSB + 2 * NUM_PAIRS - 1;

    // Swap each address pair when enabled; untouched bits pass through (R10).
    always_comb begin
        addr_out = addr_in;
        if (enable) begin
            for (int p = 0; p < NUM_PAIRS; p++) begin
                addr_out[FIRST_LSB + 2 * p]     = addr_in[FIRST_LSB + 2 * p + 1];
                addr_out[FIRST_LSB + 2 * p + 1] = addr_in[FIRST_LSB + 2 * p];
            end
        end
    end

    // Swap the two low bank bits when enabled (R10).
    always_comb begin
        bank_out = bank_in;
        if (enable) begin
            bank_out[0] = bank_in[1];
            bank_out[1] = bank_in[0];
        end
    end

    initial begin
        assert (LAST_BIT < ADDR_W);
    end
endmodule

// File: rtl/mrs_cmd_builder.sv
// Module: mrs_cmd_builder
// Builds a registered DDR3 mode-register-set command word (bank + address)
// from a strobed request. Output appears one cycle after the strobe with a
// one-cycle valid. Assumes synchronous active-low reset and that the request
// inputs are stable on the strobe edge.
module mrs_cmd_builder
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_strobe,
    input  logic [1:0]               req_mr,
    input  logic                     req_mirror,
    input  logic                     mr0_fast_pd,
    input  logic [4:0]               mr0_twr,
    input  logic                     mr0_dll_reset,
    input  logic                     mr0_test_mode,
    input  logic [4:0]               mr0_cas,
    input  logic                     mr0_interleave,
    input  logic [1:0]               mr0_burst_len,
    input  logic                     mr1_out_off,
    input  logic                     mr1_tdqs_en,
    input  logic [2:0]               mr1_rtt_nom,
    input  logic                     mr1_wr_level,
    input  logic [1:0]               mr1_drive,
    input  logic [1:0]               mr1_add_lat,
    input  logic                     mr1_dll_off,
    input  logic [1:0]               mr2_rtt_wr,
    input  logic                     mr2_ext_temp,
    input  logic                     mr2_auto_sr,
    input  logic [3:0]               mr2_cwl,
    input  logic                     mr3_mpr_en,
    output logic                     cmd_valid,
    output logic [ADDR_W+BANK_W-1:0] cmd_word
);
    localparam int CMD_W = ADDR_W + BANK_W;

    mr0_fields_t       f0;
    mr1_fields_t       f1;
    mr2_fields_t       f2;
    logic [ADDR_W-1:0] addr0, addr1, addr2, addr3;
    logic [ADDR_W-1:0] addr_sel, addr_fin;
    logic [BANK_W-1:0] bank_sel, bank_fin;

    // Pack the request ports into per-register field structures.
    always_comb begin
        f0 = '{fast_pd: mr0_fast_pd, twr: mr0_twr, dll_reset: mr0_dll_reset,
               test_mode: mr0_test_mode, cas: mr0_cas,
               interleave: mr0_interleave, burst_len: mr0_burst_len};
        f1 = '{out_off: mr1_out_off, tdqs_en: mr1_tdqs_en,
               rtt_nom: mr1_rtt_nom, wr_level: mr1_wr_level,
               drive: mr1_drive, add_lat: mr1_add_lat, dll_off: mr1_dll_off};
        f2 = '{rtt_wr: mr2_rtt_wr, ext_temp: mr2_ext_temp,
               auto_sr: mr2_auto_sr, cwl: mr2_cwl};
    end

    mrs_mr0_enc #(.ADDR_W(ADDR_W)) u_mr0 (.fields(f0), .addr(addr0));
    mrs_mr1_enc #(.ADDR_W(ADDR_W)) u_mr1 (.fields(f1), .addr(addr1));
    mrs_mr23_enc #(.ADDR_W(ADDR_W)) u_mr23 (
        .fields2(f2), .mpr_en(mr3_mpr_en), .addr2(addr2), .addr3(addr3)
    );

    // Pick the address of the selected register; the bank carries its number (R1, R9).
    always_comb begin
        case (mr_sel_e'(req_mr))
            MR_SEL0: addr_sel = addr0;
            MR_SEL1: addr_sel = addr1;
            MR_SEL2: addr_sel = addr2;
            default: addr_sel = addr3;
        endcase
        bank_sel = BANK_W'(req_mr);
    end

    mrs_mirror #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .FIRST_LSB(3), .NUM_PAIRS(3)
    ) u_mirror (
        .enable(req_mirror), .addr_in(addr_sel), .bank_in(bank_sel),
        .addr_out(addr_fin), .bank_out(bank_fin)
    );

    // Output register: capture on strobe, pulse valid for one cycle (R11, R12).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
        end else begin
            cmd_valid <= req_strobe;
            if (req_strobe)
                cmd_word <= {bank_fin, addr_fin};
        end
    end

    // Assertions guarding the output stage and bank/address framing.
    assert_valid_after_strobe_R11: assert property (
        @(posedge clk) disable iff (!rst_n) req_strobe |=> cmd_valid);
    assert_valid_single_R11: assert property (
        @(posedge clk) disable iff (!rst_n) !req_strobe |=> !cmd_valid);
    assert_word_hold_R11: assert property (
        @(posedge clk) disable iff (!rst_n) !req_strobe |=> $stable(cmd_word));
    assert_bank_plain_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_strobe && !req_mirror) |=> cmd_word[CMD_W-1:ADDR_W] == BANK_W'($past(req_mr)));
    assert_bank_mirror_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_strobe && req_mirror) |=>
        cmd_word[CMD_W-1:ADDR_W] == BANK_W'({$past(req_mr[0]), $past(req_mr[1])}));
    assert_upper_zero_R9: assert property (
        @(posedge clk) disable iff (!rst_n) cmd_valid |-> cmd_word[ADDR_W-1:13] == '0);
    assert_mr3_only_mpr_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_strobe && req_mr == 2'd3) |=>
        cmd_word[ADDR_W-1:0] == ADDR_W'({$past(mr3_mpr_en), 2'b00}));
    assert_reset_clear_R12: assert property (
        @(posedge clk) !rst_n |=> (!cmd_valid && cmd_word == '0));
endmodule

// File: tb/mrs_cmd_builder_tb.sv
`timescale 1ns/1ps
module mrs_cmd_builder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_strobe = 1'b0;
    logic [1:0] req_mr = '0;
    logic req_mirror = 1'b0;
    logic mr0_fast_pd = 0, mr0_dll_reset = 0, mr0_test_mode = 0, mr0_interleave = 0;
    logic [4:0] mr0_twr = '0, mr0_cas = '0;
    logic [1:0] mr0_burst_len = '0;
    logic mr1_out_off = 0, mr1_tdqs_en = 0, mr1_wr_level = 0, mr1_dll_off = 0;
    logic [2:0] mr1_rtt_nom = '0;
    logic [1:0] mr1_drive = '0, mr1_add_lat = '0;
    logic [1:0] mr2_rtt_wr = '0;
    logic mr2_ext_temp = 0, mr2_auto_sr = 0;
    logic [3:0] mr2_cwl = '0;
    logic mr3_mpr_en = 0;
    logic cmd_valid;
    logic [18:0] cmd_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    mrs_cmd_builder dut_i (
        .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe), .req_mr(req_mr),
        .req_mirror(req_mirror), .mr0_fast_pd(mr0_fast_pd), .mr0_twr(mr0_twr),
        .mr0_dll_reset(mr0_dll_reset), .mr0_test_mode(mr0_test_mode),
        .mr0_cas(mr0_cas), .mr0_interleave(mr0_interleave),
        .mr0_burst_len(mr0_burst_len), .mr1_out_off(mr1_out_off),
        .mr1_tdqs_en(mr1_tdqs_en), .mr1_rtt_nom(mr1_rtt_nom),
        .mr1_wr_level(mr1_wr_level), .mr1_drive(mr1_drive),
        .mr1_add_lat(mr1_add_lat), .mr1_dll_off(mr1_dll_off),
        .mr2_rtt_wr(mr2_rtt_wr), .mr2_ext_temp(mr2_ext_temp),
        .mr2_auto_sr(mr2_auto_sr), .mr2_cwl(mr2_cwl), .mr3_mpr_en(mr3_mpr_en),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word)
    );

    function automatic int unsigned next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    // Put random values on every field input.
    task automatic scramble();
        int unsigned r = next_rand();
        int unsigned s = next_rand();
        mr0_fast_pd = r[0]; mr0_twr = r[5:1]; mr0_dll_reset = r[6];
        mr0_test_mode = r[7]; mr0_cas = r[12:8]; mr0_interleave = r[13];
        mr0_burst_len = r[15:14]; mr1_out_off = r[16]; mr1_tdqs_en = r[17];
        mr1_rtt_nom = r[20:18]; mr1_wr_level = r[21]; mr1_drive = r[23:22];
        mr1_add_lat = s[1:0]; mr1_dll_off = s[2]; mr2_rtt_wr = s[4:3];
        mr2_ext_temp = s[5]; mr2_auto_sr = s[6]; mr2_cwl = s[10:7];
        mr3_mpr_en = s[11];
    endtask

    // Expected command word computed arithmetically from the requirement text.
    function automatic int expected_word();
        int a = 0;
        int b = int'(req_mr);
        int t = int'(mr0_twr);
        int tc, k, lo, hi;
        case (req_mr)
            2'd0: begin
                if (t >= 5 && t <= 8) tc = t - 4;
                else if (t >= 9 && t <= 14) tc = (t + 1) / 2;
                else tc = 0;
                k = (int'(mr0_cas) + 12) % 16;
                a = int'(mr0_fast_pd) * 4096 + tc * 512 + int'(mr0_dll_reset) * 256
                  + int'(mr0_test_mode) * 128 + (k % 8) * 16 + int'(mr0_interleave) * 8
                  + (k / 8) * 4 + int'(mr0_burst_len);
            end
            2'd1: begin
                a = int'(mr1_out_off) * 4096 + int'(mr1_tdqs_en) * 2048
                  + (int'(mr1_rtt_nom) / 4) * 512 + ((int'(mr1_rtt_nom) / 2) % 2) * 64
                  + (int'(mr1_rtt_nom) % 2) * 4 + (int'(mr1_drive) / 2) * 32
                  + (int'(mr1_drive) % 2) * 2 + int'(mr1_wr_level) * 128
                  + int'(mr1_add_lat) * 8 + int'(mr1_dll_off);
            end
            2'd2: begin
                a = int'(mr2_rtt_wr) * 512 + int'(mr2_ext_temp) * 128
                  + int'(mr2_auto_sr) * 64 + ((int'(mr2_cwl) + 3) % 8) * 8;
            end
            default: a = int'(mr3_mpr_en) * 4;
        endcase
        if (req_mirror) begin
            for (int p = 3; p <= 7; p += 2) begin
                lo = (a >> p) % 2;
                hi = (a >> (p + 1)) % 2;
                a = a - (lo << p) - (hi << (p + 1)) + (hi << p) + (lo << (p + 1));
            end
            b = (b % 2) * 2 + (b / 2) % 2;
        end
        return b * 65536 + a;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%05h expected=0x%05h", tag, act, exp);
        end
    endtask

    // Issue one request with the fields as set; check word, pulse and hold.
    task automatic issue(logic [1:0] mr, logic mir, string tag);
        int exp;
        @(negedge clk);
        req_mr = mr; req_mirror = mir; req_strobe = 1'b1;
        exp = expected_word();
        @(negedge clk);
        req_strobe = 1'b0;
        check("R11 valid pulse", int'(cmd_valid), 1);
        check(tag, int'(cmd_word), exp);
        scramble();
        req_mr = 2'(next_rand()); req_mirror = ~mir;
        @(negedge clk);
        check("R11 valid low and word held", int'(cmd_valid) * 65536 * 8 + int'(cmd_word), exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        int e1, e2;
        scramble();
        req_strobe = 1'b1;
        repeat (3) @(negedge clk);
        check("R12 reset valid", int'(cmd_valid), 0);
        check("R12 reset word", int'(cmd_word), 0);
        req_strobe = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle valid", int'(cmd_valid), 0);

        // R2: every write recovery value, mirrored and not.
        for (int t = 0; t < 32; t++) begin
            scramble(); mr0_twr = 5'(t);
            issue(2'd0, 1'b0, "R2 twr");
            scramble(); mr0_twr = 5'(t);
            issue(2'd0, 1'b1, "R10 twr mirrored");
        end
        // R3: every CAS value.
        for (int c = 0; c < 32; c++) begin
            scramble(); mr0_cas = 5'(c);
            issue(2'd0, 1'b0, "R3 cas");
        end
        // R4: all single-bit and burst-length combinations.
        for (int i = 0; i < 64; i++) begin
            scramble();
            {mr0_fast_pd, mr0_dll_reset, mr0_test_mode, mr0_interleave, mr0_burst_len} = 6'(i);
            issue(2'd0, 1'b0, "R4 mr0 flags");
        end
        // R5: all termination and drive codes.
        for (int i = 0; i < 32; i++) begin
            scramble(); mr1_rtt_nom = 3'(i); mr1_drive = 2'(i >> 3);
            issue(2'd1, 1'b0, "R5 rtt/drive");
        end
        // R6: remaining register-1 fields.
        for (int i = 0; i < 64; i++) begin
            scramble();
            {mr1_out_off, mr1_tdqs_en, mr1_wr_level, mr1_add_lat, mr1_dll_off} = 6'(i);
            issue(2'd1, 1'b0, "R6 mr1 fields");
        end
        // R7: all register-2 combinations.
        for (int i = 0; i < 256; i++) begin
            scramble();
            {mr2_rtt_wr, mr2_ext_temp, mr2_auto_sr, mr2_cwl} = 8'(i);
            issue(2'd2, 1'b0, "R7 mr2");
        end
        // R8: register 3 both ways.
        for (int i = 0; i < 2; i++) begin
            scramble(); mr3_mpr_en = 1'(i);
            issue(2'd3, 1'b0, "R8 mr3");
        end
        // R9 and R10: random register, random fields, random mirroring.
        for (int i = 0; i < 200; i++) begin
            int unsigned r = next_rand();
            scramble();
            issue(r[1:0], r[2], r[2] ? "R10 mirror" : "R9 unrelated fields");
            check("R1 bank bits", int'(cmd_word[18:16]),
                  r[2] ? int'({1'b0, r[0], r[1]}) : int'(r[1:0]));
        end

        // R11: back-to-back strobes.
        @(negedge clk);
        scramble(); req_mr = 2'd2; req_mirror = 1'b0; req_strobe = 1'b1;
        e1 = expected_word();
        @(negedge clk);
        check("R11 back-to-back first", int'(cmd_word), e1);
        check("R11 back-to-back valid 1", int'(cmd_valid), 1);
        scramble(); req_mr = 2'd1; req_mirror = 1'b1;
        e2 = expected_word();
        @(negedge clk);
        req_strobe = 1'b0;
        check("R11 back-to-back second", int'(cmd_word), e2);
        check("R11 back-to-back valid 2", int'(cmd_valid), 1);
        @(negedge clk);
        check("R11 pulse ends", int'(cmd_valid), 0);

        // R12: reset clears a loaded word.
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 reset clears word", int'(cmd_word), 0);
        check("R12 reset clears valid", int'(cmd_valid), 0);
        rst_n = 1'b1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule